// File: doc/BRIEF.md
# Timer Interrupt Flag Register

This block holds the pending-event flags of a group of timer interrupt sources. Each timer source sends a one-cycle pulse when its event happens, such as a counter wrapping past its top value, a match against a compare value, or a captured count being stored. The pulse latches a flag that stays set until software or the interrupt controller clears it. Software can read the flags and poll them at any time, whether or not the source is enabled.

Each flag has two clear paths. Software can write a one to the flag's bit. The interrupt controller can also send a per-source acknowledge pulse when it dispatches that source's vector. A source asserts its request line only while three things are all true: its flag is set, its own enable is set, and the global interrupt enable is set. The number of sources is a parameter. With the default of four, the bit order is: bit 0 counter-0 overflow, bit 1 counter-0 compare, bit 2 counter-2 compare, bit 3 counter-1 capture. The same order is used by every vector port.

Top module: `timer_irq_flags`

## Requirements
- R1: While reset is active and after it is released, every flag reads 0 and every request output is 0.
- R2: A one-cycle pulse on `evtPulse[i]` sets flag i. The flag shows on `rdData[i]` from the next rising clock edge onward.
- R3: A cycle with `wrEn` high clears every flag whose `wrData` bit is 1. A flag whose `wrData` bit is 0 keeps its value.
- R4: A pulse on `ackPulse[i]` clears flag i at the next edge.
- R5: If an event on source i arrives in the same cycle as a write-one or an acknowledge on source i, the flag ends up at 1.
- R6: `irqReq[i]` is the AND of flag i, `srcEnable[i]` and `globalEn`. It is combinational, so a change in either enable shows on `irqReq` in the same cycle.
- R7: A set flag stays at 1 while its enable or the global enable is 0, as long as no clear reaches it.
- R8: An acknowledge on a flag that is 0 leaves that flag at 0 and changes no other flag.
- R9: An event, write-one or acknowledge on one source never changes the flag of any other source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrData | input | NUM_SRC | Write data; a 1 clears the matching flag |
| rdData | output | NUM_SRC | Current flag values |
| evtPulse | input | NUM_SRC | One-cycle event pulses from the timers |
| srcEnable | input | NUM_SRC | Per-source interrupt enables |
| globalEn | input | 1 | Global interrupt enable |
| ackPulse | input | NUM_SRC | Per-source vector-dispatch acknowledge |
| irqReq | output | NUM_SRC | Per-source interrupt requests |

## Verification
The hardest case to reach is a collision on one source: its set pulse lands in the same cycle as its own clear, whether that clear is a write-one or an acknowledge. Normal traffic rarely lines these up. The stimulus therefore drives each collision on purpose, once through the write path and once through the acknowledge path, while other sources are being cleared in that same cycle. This shows that the set wins and that the neighbouring bits are not disturbed. Acknowledges aimed at flags that are already clear are also issued while other flags are set.

// File: rtl/timer_irq_flags_pkg.sv
package timer_irq_flags_pkg;

  // Per-source strobes sent from control to datapath
  typedef struct packed {
    logic set;
    logic clr;
  } flagStrobe_t;

endpackage

// File: rtl/timer_irq_flags_ctrl.sv
module timer_irq_flags_ctrl
  import timer_irq_flags_pkg::*;
#(
  parameter int NUM_SRC = 4
) (
  input  logic                       wrEn,
  input  logic [NUM_SRC-1:0]         wrData,
  input  logic [NUM_SRC-1:0]         evtPulse,
  input  logic [NUM_SRC-1:0]         ackPulse,
  output flagStrobe_t [NUM_SRC-1:0]  strobes
);

  logic [NUM_SRC-1:0] writeClr;

  assign writeClr = wrEn ? wrData : '0;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_strobe
    always_comb begin
      strobes[i].set = evtPulse[i];
      strobes[i].clr = writeClr[i] | ackPulse[i];
    end
  end

endmodule

// File: rtl/timer_irq_flags_dp.sv
module timer_irq_flags_dp
  import timer_irq_flags_pkg::*;
#(
  parameter int NUM_SRC = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  flagStrobe_t [NUM_SRC-1:0]  strobes,
  input  logic [NUM_SRC-1:0]         srcEnable,
  input  logic                       globalEn,
  output logic [NUM_SRC-1:0]         flagQ,
  output logic [NUM_SRC-1:0]         irqReq
);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                flagQ[i] <= 1'b0;
      else if (strobes[i].set)  flagQ[i] <= 1'b1;
      else if (strobes[i].clr)  flagQ[i] <= 1'b0;
    end

    assign irqReq[i] = flagQ[i] & srcEnable[i] & globalEn;

    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rstN)
      strobes[i].set |=> flagQ[i]);

    assert_clear_takes_R4: assert property (@(posedge clk) disable iff (!rstN)
      (strobes[i].clr && !strobes[i].set) |=> !flagQ[i]);

    assert_flag_held_R7: assert property (@(posedge clk) disable iff (!rstN)
      (!strobes[i].clr && !strobes[i].set) |=> $stable(flagQ[i]));
  end

endmodule

// File: rtl/timer_irq_flags.sv
module timer_irq_flags
  import timer_irq_flags_pkg::*;
#(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [NUM_SRC-1:0] wrData,
  output logic [NUM_SRC-1:0] rdData,
  input  logic [NUM_SRC-1:0] evtPulse,
  input  logic [NUM_SRC-1:0] srcEnable,
  input  logic               globalEn,
  input  logic [NUM_SRC-1:0] ackPulse,
  output logic [NUM_SRC-1:0] irqReq
);

  flagStrobe_t [NUM_SRC-1:0] strobes;

  timer_irq_flags_ctrl #(.NUM_SRC(NUM_SRC)) u_ctrl (
    .wrEn     (wrEn),
    .wrData   (wrData),
    .evtPulse (evtPulse),
    .ackPulse (ackPulse),
    .strobes  (strobes)
  );

  timer_irq_flags_dp #(.NUM_SRC(NUM_SRC)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .srcEnable (srcEnable),
    .globalEn  (globalEn),
    .flagQ     (rdData),
    .irqReq    (irqReq)
  );

  assert_no_req_without_gie_R6: assert property (@(posedge clk) disable iff (!rstN)
    !globalEn |-> (irqReq == '0));

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_port_chk
    assert_req_when_armed_R6: assert property (@(posedge clk) disable iff (!rstN)
      (rdData[i] && srcEnable[i] && globalEn) |-> irqReq[i]);

    assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
      evtPulse[i] |=> rdData[i]);

    assert_write_one_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && wrData[i] && !evtPulse[i]) |=> !rdData[i]);

    assert_write_zero_keeps_R3: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && !wrData[i] && !evtPulse[i] && !ackPulse[i]) |=> $stable(rdData[i]));

    assert_ack_idle_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
      (ackPulse[i] && !rdData[i] && !evtPulse[i]) |=> !rdData[i]);
  end

endmodule

// File: tb/test_timer_irq_flags.sv
module test_timer_irq_flags;

  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0;
  logic [N-1:0] wrData = '0;
  logic [N-1:0] rdData;
  logic [N-1:0] evtPulse = '0;
  logic [N-1:0] srcEnable = '0;
  logic         globalEn = 1'b0;
  logic [N-1:0] ackPulse = '0;
  logic [N-1:0] irqReq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [N-1:0] flags;
    logic [N-1:0] req;
    string        tag;
  } expItem_t;

  expItem_t     expQ[$];
  logic [N-1:0] model = '0;

  always #4 clk = ~clk;  // 125 MHz

  timer_irq_flags #(.NUM_SRC(N)) i_timer_irq_flags (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .evtPulse(evtPulse), .srcEnable(srcEnable), .globalEn(globalEn),
    .ackPulse(ackPulse), .irqReq(irqReq)
  );

  function automatic void cmp(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endfunction

  // Driver: one cycle of stimulus, expected result pushed to the scoreboard
  task automatic step(input logic [N-1:0] evt, input logic we, input logic [N-1:0] wd,
                      input logic [N-1:0] ack, input logic [N-1:0] en, input logic g,
                      input string tag);
    expItem_t it;
    logic [N-1:0] clr;
    @(negedge clk);
    evtPulse = evt; wrEn = we; wrData = wd; ackPulse = ack;
    srcEnable = en; globalEn = g;
    clr = (we ? wd : '0) | ack;
    model = evt | (model & ~clr);
    it.flags = model;
    it.req = model & en & {N{g}};
    it.tag = tag;
    expQ.push_back(it);
    @(posedge clk);
  endtask

  // Monitor: compares after each edge
  always @(posedge clk) begin
    #2;
    if (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      cmp({it.tag, " flags"}, rdData, it.flags);
      cmp({it.tag, " req"}, irqReq, it.req);
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp("R1 reset flags", rdData, '0);
    cmp("R1 reset req", irqReq, '0);
    rstN = 1'b1;
    step('0, 0, '0, '0, '0, 0, "R1 after release");

    // R2 / R7: set with everything disabled, flag stays latched
    step(4'b0001, 0, '0, '0, '0, 0, "R2 set bit0");
    step('0, 0, '0, '0, 4'b1111, 0, "R7 held gie off");
    step('0, 0, '0, '0, 4'b0000, 1, "R7 held en off");
    step(4'b1000, 0, '0, '0, 4'b1111, 0, "R2 set bit3");
    step('0, 0, '0, '0, 4'b1111, 1, "R6 req both");

    // R6: combinational enable path, same cycle
    @(negedge clk);
    srcEnable = 4'b1000; globalEn = 1'b1;
    #1 cmp("R6 comb en drop", irqReq, 4'b1000);
    globalEn = 1'b0;
    #1 cmp("R6 comb gie drop", irqReq, 4'b0000);
    globalEn = 1'b1;
    #1 cmp("R6 comb gie rise", irqReq, 4'b1000);

    // R3: write zero keeps, write one clears only its bit (R9)
    step('0, 1, 4'b0000, '0, 4'b1111, 1, "R3 write zero");
    step('0, 1, 4'b0001, '0, 4'b1111, 1, "R3 R9 write one bit0");
    // R4 / R8
    step(4'b0100, 0, '0, '0, 4'b1111, 1, "R2 set bit2");
    step('0, 0, '0, 4'b1000, 4'b1111, 1, "R4 R9 ack bit3");
    step('0, 0, '0, 4'b0010, 4'b1111, 1, "R8 ack idle bit1");
    // R5 collisions, with neighbour clears in the same cycle
    step(4'b0100, 1, 4'b0100, '0, 4'b1111, 1, "R5 set vs write");
    step(4'b0011, 0, '0, 4'b0110, 4'b1111, 1, "R5 set vs ack");
    step(4'b1000, 1, 4'b1111, 4'b0001, 4'b1111, 1, "R5 R9 mixed");
    // walking patterns
    for (int k = 0; k < N; k++) begin
      step(4'b0001 << k, 0, '0, '0, 4'b0101, 1, "R2 R9 walk set");
      step('0, 1, 4'b0001 << ((k + 1) % N), '0, 4'b0101, 1, "R3 R9 walk write");
      step('0, 0, '0, 4'b0001 << ((k + 2) % N), 4'b1010, 1, "R4 R9 walk ack");
    end
    step('0, 1, 4'b1111, '0, 4'b1111, 1, "R3 clear all");
    step('0, 0, '0, 4'b1111, 4'b1111, 1, "R8 ack all idle");

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule